// File: doc/BRIEF.md
# Heartbeat Watchdog Supervisor

This block watches a heartbeat line that a healthy subsystem keeps toggling, at about 750 Hz in the intended use. After a two-flop synchronizer it turns each change of level into a one-cycle event. It counts core clock cycles between events.

A fault is raised in either of two cases:
- the line stays at one level for too long; the default is 200 ms, which is far longer than the nominal period;
- two events arrive closer together than a minimum pulse width; the default is 100 ns, which catches glitch-short pulses.

A fault starts an active-low reset pulse of a fixed, guaranteed length; the default is 1 ms. A start-up grace period follows the pulse. During the pulse and the grace period the interval counter is held clear. Monitoring resumes only when the grace period ends.

An active-low mute output marks every interval in which the supervised path is not trusted: power-on reset, the start-up grace, the reset pulse and the grace after it. All thresholds are parameters in clock cycles. Their defaults are derived from a clock-frequency parameter.

Top module: `hb_supervisor`

## Requirements
- R1: While `rst_ni` is low, `rst_n_o` is 1, `mute_n_o` is 0 and `fault_o` is 0.
- R2: After `rst_ni` rises, the block spends GRACE_CYC cycles in start-up grace with `mute_n_o` low, counting the cycle in which reset is released. Heartbeat toggles of any spacing during the grace raise no fault and start no reset. `mute_n_o` is 1 once the grace has ended.
- R3: While monitoring, successive heartbeat changes spaced at least MIN_PULSE_CYC cycles apart and less than TIMEOUT_CYC cycles apart raise no fault.
- R4: While monitoring, if the heartbeat holds one level for TIMEOUT_CYC cycles after its last change, `fault_o` rises within a few cycles of synchronizer latency. It does not rise earlier.
- R5: While monitoring, two heartbeat changes spaced fewer than MIN_PULSE_CYC cycles apart raise a fault. The first change after monitoring resumes is not width-checked, because it has no measured predecessor.
- R6: A fault drives `rst_n_o` low, starting in the cycle after detection, for exactly RST_CYC cycles.
- R7: `fault_o` stays 1 from the cycle after detection until monitoring resumes. `mute_n_o` is low for exactly RST_CYC + GRACE_CYC cycles after a fault.
- R8: After a fault, timeout counting is held during the reset pulse and the following grace. With a silent heartbeat, the next reset pulse starts only TIMEOUT_CYC cycles after monitoring resumes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hb_i | input | 1 | Heartbeat line, asynchronous to `clk_i` |
| fault_o | output | 1 | High from fault detection until monitoring resumes |
| rst_n_o | output | 1 | Active-low reset pulse produced on a fault |
| mute_n_o | output | 1 | Active-low mute; high only while monitoring |

## Verification
The bench targets three boundaries.

Pulse-width boundary (R3, R5):
- A spacing of exactly MIN_PULSE_CYC must pass.
- A spacing one cycle shorter must fault.
- An off-by-one in the width compare would flip one of these two results.

Timeout window (R4): the bench looks just before and just after TIMEOUT_CYC of silence. A counter that starts late or compares one step off would fault too early or not at all.

Reset pulse and hold-off (R6, R7, R8):
- The bench counts exact low-cycle totals on `rst_n_o` and `mute_n_o`, so a pulse stretched or cut by one cycle is caught.
- It lets the heartbeat stay silent through the recovery. A counter that kept running during the hold would fire a second reset right after the grace.
- It toggles the heartbeat during the start-up grace. A monitor enabled too early would flag those toggles as glitches.

// File: rtl/hb_pkg.sv
package hb_pkg;

    typedef enum logic [1:0] {
        SV_GRACE = 2'd0,
        SV_RUN   = 2'd1,
        SV_HOLD  = 2'd2
    } sv_state_e;

endpackage

// File: rtl/hb_sync_edge.sv
module hb_sync_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic hb_i,
    output logic edge_o
);

    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              last;
    } sync_t;

    sync_t sync_d, sync_q;
    logic [STAGES:0] chain;

    assign chain[0] = hb_i;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_chain
            assign chain[g+1] = sync_q.sync[g];
        end
    endgenerate

    always_comb begin
        sync_d      = sync_q;
        sync_d.sync = chain[STAGES-1:0];
        sync_d.last = sync_q.sync[STAGES-1];
        edge_o      = sync_q.sync[STAGES-1] ^ sync_q.last;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

endmodule

// File: rtl/hb_interval_mon.sv
module hb_interval_mon #(
    parameter int unsigned TIMEOUT_CYC   = 400,
    parameter int unsigned MIN_PULSE_CYC = 6
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    input  logic edge_i,
    output logic fault_o
);

    localparam int unsigned CNT_W = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CNT_W-1:0] TO_LIM  = CNT_W'(TIMEOUT_CYC - 1);
    localparam logic [CNT_W-1:0] MIN_LIM = CNT_W'(MIN_PULSE_CYC - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             seen;
    } mon_t;

    mon_t mon_d, mon_q;
    logic timeout, glitch;

    always_comb begin
        mon_d   = mon_q;
        timeout = 1'b0;
        glitch  = 1'b0;
        if (!en_i) begin
            mon_d.cnt  = '0;
            mon_d.seen = 1'b0;
        end else if (edge_i) begin
            // interval in cycles is cnt + 1
            glitch     = mon_q.seen && (mon_q.cnt < MIN_LIM);
            mon_d.cnt  = '0;
            mon_d.seen = 1'b1;
        end else if (mon_q.cnt == TO_LIM) begin
            timeout = 1'b1;
        end else begin
            mon_d.cnt = mon_q.cnt + 1'b1;
        end
        fault_o = timeout | glitch;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            mon_q <= '0;
        end else begin
            mon_q <= mon_d;
        end
    end

    AST_CNT_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mon_q.cnt <= TO_LIM); // R4

    AST_IDLE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> (mon_q.cnt == '0 && !mon_q.seen)); // R8

endmodule

// File: rtl/hb_rst_stretch.sv
module hb_rst_stretch
    import hb_pkg::*;
#(
    parameter int unsigned RST_CYC   = 50,
    parameter int unsigned GRACE_CYC = 80
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic fault_i,
    output logic mon_en_o,
    output logic fault_o,
    output logic rst_n_o,
    output logic mute_n_o
);

    localparam int unsigned MAX_CYC = (RST_CYC > GRACE_CYC) ? RST_CYC : GRACE_CYC;
    localparam int unsigned TMR_W   = $clog2(MAX_CYC + 1);
    localparam logic [TMR_W-1:0] RS_LIM = TMR_W'(RST_CYC - 1);
    localparam logic [TMR_W-1:0] GR_LIM = TMR_W'(GRACE_CYC - 1);

    typedef struct packed {
        sv_state_e        st;
        logic [TMR_W-1:0] tmr;
        logic             flt;
    } stretch_t;

    stretch_t str_d, str_q;

    always_comb begin
        str_d = str_q;
        unique case (str_q.st)
            SV_GRACE: begin
                if (str_q.tmr == GR_LIM) begin
                    str_d.st  = SV_RUN;
                    str_d.tmr = '0;
                    str_d.flt = 1'b0;
                end else begin
                    str_d.tmr = str_q.tmr + 1'b1;
                end
            end
            SV_RUN: begin
                if (fault_i) begin
                    str_d.st  = SV_HOLD;
                    str_d.tmr = '0;
                    str_d.flt = 1'b1;
                end
            end
            SV_HOLD: begin
                if (str_q.tmr == RS_LIM) begin
                    str_d.st  = SV_GRACE;
                    str_d.tmr = '0;
                end else begin
                    str_d.tmr = str_q.tmr + 1'b1;
                end
            end
            default: begin
                str_d.st  = SV_GRACE;
                str_d.tmr = '0;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            str_q.st  <= SV_GRACE;
            str_q.tmr <= '0;
            str_q.flt <= 1'b0;
        end else begin
            str_q <= str_d;
        end
    end

    assign mon_en_o = (str_q.st == SV_RUN);
    assign fault_o  = str_q.flt;
    assign rst_n_o  = (str_q.st != SV_HOLD);
    assign mute_n_o = (str_q.st == SV_RUN);

    AST_FAULT_STARTS_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mon_en_o && fault_i) |=> !rst_n_o); // R6

    AST_RST_MIN_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!rst_n_o && str_q.tmr != RS_LIM) |=> !rst_n_o); // R6

    AST_MUTE_WITH_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rst_n_o |-> (!mute_n_o && fault_o)); // R7

    AST_GRACE_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (str_q.st == SV_GRACE && str_q.tmr != GR_LIM) |=> !mute_n_o); // R2

    AST_HOLD_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (str_q.st == SV_HOLD) |=> (str_q.st == SV_HOLD || str_q.st == SV_GRACE)); // R8

endmodule

// File: rtl/hb_supervisor.sv
module hb_supervisor #(
    parameter int unsigned CLK_HZ        = 200_000_000,
    parameter int unsigned TIMEOUT_CYC   = CLK_HZ / 5,
    parameter int unsigned MIN_PULSE_CYC = (CLK_HZ / 10_000_000 > 1) ? CLK_HZ / 10_000_000 : 2,
    parameter int unsigned RST_CYC       = CLK_HZ / 1000,
    parameter int unsigned GRACE_CYC     = CLK_HZ / 100,
    parameter int unsigned SYNC_STAGES   = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic hb_i,
    output logic fault_o,
    output logic rst_n_o,
    output logic mute_n_o
);

    logic hb_edge;
    logic mon_fault;
    logic mon_en;

    hb_sync_edge #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .hb_i   (hb_i),
        .edge_o (hb_edge)
    );

    hb_interval_mon #(
        .TIMEOUT_CYC   (TIMEOUT_CYC),
        .MIN_PULSE_CYC (MIN_PULSE_CYC)
    ) u_mon (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .en_i    (mon_en),
        .edge_i  (hb_edge),
        .fault_o (mon_fault)
    );

    hb_rst_stretch #(
        .RST_CYC   (RST_CYC),
        .GRACE_CYC (GRACE_CYC)
    ) u_stretch (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .fault_i  (mon_fault),
        .mon_en_o (mon_en),
        .fault_o  (fault_o),
        .rst_n_o  (rst_n_o),
        .mute_n_o (mute_n_o)
    );

    AST_RESET_STATE: assert property (@(posedge clk_i)
        !rst_ni |-> (rst_n_o && !mute_n_o && !fault_o)); // R1

endmodule

// File: tb/hb_supervisor_tb_top.sv
`timescale 1ns/1ps
module hb_supervisor_tb_top;

    localparam int TO_C  = 400;
    localparam int MIN_C = 6;
    localparam int RST_C = 50;
    localparam int GR_C  = 80;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hb = 1'b0;
    logic fault_o, rst_n_o, mute_n_o;

    always #2.5 clk = ~clk;

    hb_supervisor #(
        .CLK_HZ        (200_000_000),
        .TIMEOUT_CYC   (TO_C),
        .MIN_PULSE_CYC (MIN_C),
        .RST_CYC       (RST_C),
        .GRACE_CYC     (GR_C),
        .SYNC_STAGES   (2)
    ) dut_i (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .hb_i     (hb),
        .fault_o  (fault_o),
        .rst_n_o  (rst_n_o),
        .mute_n_o (mute_n_o)
    );

    int checks = 0;
    int fails = 0;
    int rst_low_cnt = 0;
    int mute_low_cnt = 0;

    // low-cycle totals, sampled away from the clock edge
    always @(posedge clk) begin
        #1.25;
        if (rst_n && !rst_n_o) rst_low_cnt++;
        if (rst_n && !mute_n_o) mute_low_cnt++;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit exp_glitch(input int w);
        return w < MIN_C;
    endfunction

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic run_pair(input int w);
        int base_r, base_m;
        bit e;
        wait_cyc(MIN_C + 2);
        hb = ~hb;
        base_r = rst_low_cnt;
        base_m = mute_low_cnt;
        wait_cyc(w);
        hb = ~hb;
        wait_cyc(6);
        e = exp_glitch(w);
        if (e) begin
            chk(fault_o == 1'b1, "R5", int'(fault_o), 1);
            chk(rst_n_o == 1'b0, "R6", int'(rst_n_o), 0);
            wait_cyc(RST_C + GR_C + 4);
            chk(rst_low_cnt - base_r == RST_C, "R6", rst_low_cnt - base_r, RST_C);
            chk(mute_low_cnt - base_m == RST_C + GR_C, "R7", mute_low_cnt - base_m, RST_C + GR_C);
            chk(fault_o == 1'b0 && mute_n_o == 1'b1, "R7", int'(fault_o), 0);
        end else begin
            chk(fault_o == 1'b0 && rst_n_o == 1'b1, "R3", int'(fault_o), 0);
        end
    endtask

    initial begin
        int lows;
        int base_r;
        void'($urandom(32'd20240611));

        // R1: reset state
        wait_cyc(5);
        chk(rst_n_o == 1'b1, "R1", int'(rst_n_o), 1);
        chk(mute_n_o == 1'b0, "R1", int'(mute_n_o), 0);
        chk(fault_o == 1'b0, "R1", int'(fault_o), 0);

        // R2: start-up grace with glitching heartbeat
        rst_n = 1'b1;
        lows = 0;
        for (int i = 0; i < GR_C + 20; i++) begin
            if (i < GR_C - 8) hb = ~hb;
            @(negedge clk);
            if (!mute_n_o) lows++;
        end
        // the release cycle itself is not sampled, hence GR_C - 1
        chk(lows == GR_C - 1, "R2", lows, GR_C - 1);
        chk(fault_o == 1'b0, "R2", int'(fault_o), 0);
        chk(rst_n_o == 1'b1, "R2", int'(rst_n_o), 1);

        // R3 / R5 boundary
        run_pair(MIN_C);
        run_pair(MIN_C - 1);
        run_pair(1);

        // random spacings, mixed pass and glitch
        for (int k = 0; k < 16; k++) begin
            run_pair(int'($urandom_range(1, MIN_C + 40)));
        end

        // R3: steady stream at legal spacing
        for (int k = 0; k < 20; k++) begin
            hb = ~hb;
            wait_cyc(int'($urandom_range(MIN_C, MIN_C + 60)));
        end
        chk(fault_o == 1'b0 && rst_n_o == 1'b1, "R3", int'(fault_o), 0);

        // R4: timeout window
        hb = ~hb;
        base_r = rst_low_cnt;
        wait_cyc(TO_C - 10);
        chk(fault_o == 1'b0 && rst_n_o == 1'b1, "R4", int'(fault_o), 0);
        wait_cyc(20);
        chk(fault_o == 1'b1, "R4", int'(fault_o), 1);

        // R8: silent heartbeat, counting held through pulse and grace
        wait_cyc(TO_C + RST_C + GR_C - 40);
        chk(rst_low_cnt - base_r == RST_C, "R8", rst_low_cnt - base_r, RST_C);
        chk(mute_n_o == 1'b1, "R8", int'(mute_n_o), 1);
        wait_cyc(50);
        chk(fault_o == 1'b1, "R8", int'(fault_o), 1);
        chk(rst_low_cnt - base_r > RST_C, "R8", rst_low_cnt - base_r, RST_C + 1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule